// File: doc/BRIEF.md
# Unsigned Divide Unit with Condition and Overflow Flags

A multi-cycle execution unit that divides an unsigned dividend by an unsigned divisor, both 64 bits wide by default. It returns only the quotient. The remainder is used internally and is not brought out. A start strobe launches an operation, and the operands are captured on that cycle. A restoring radix-2 datapath then retires one quotient bit per clock. A single-cycle done strobe marks the result.

Each operation carries two independent controls. The record control asks for a three-bit condition field. This field comes from comparing the quotient with zero as a signed two's-complement number. The overflow-enable control lets the operation update the overflow flag. The overflow flag reports a zero divisor, and a sticky summary flag collects every overflow until a dedicated clear input resets it. A zero divisor never stalls the unit: it is detected at start and completes at once with a fixed result.

Top module: `udiv_unit`

## Requirements
- R1: `done_o` is high for exactly one cycle per accepted operation. With a nonzero divisor it rises after the 65th clock edge following the edge that accepts `start_i`. `quot_o` changes only when `done_o` is high.
- R2: With a nonzero divisor, `quot_o` is the unsigned quotient floor(dividend/divisor). This means dividend = quot*divisor + r with 0 <= r < divisor.
- R3: With a zero divisor, `done_o` rises after the accepting edge itself, and `quot_o` is all zeros.
- R4: When the record control was 1 at start, `cr_valid_o` is high together with `done_o`. `cr_o` is then 3'b100 (less) if quotient bit 63 is set, 3'b001 (equal) if the quotient is zero, and 3'b010 (greater) otherwise. When the record control was 0, `cr_valid_o` stays low and `cr_o` keeps its previous value.
- R5: With a zero divisor and the record control at 1, `cr_o` is 3'b001.
- R6: When overflow-enable was 1 at start, `ov_o` becomes 1 at done if the divisor was zero and 0 otherwise. When overflow-enable was 0, `ov_o` keeps its value.
- R7: `so_o` becomes 1 whenever `ov_o` is set. `so_clr_i` clears `so_o` at the next edge, except when a set occurs at that same edge, in which case the set wins.
- R8: `start_i` is ignored while an operation is in progress. Operand and control inputs are sampled only on the accepting edge.
- R9: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation (accepted when idle) |
| dividend_i | input | 64 | Unsigned dividend |
| divisor_i | input | 64 | Unsigned divisor |
| ovf_en_i | input | 1 | Operation may update the overflow flag |
| rec_en_i | input | 1 | Operation produces the condition field |
| so_clr_i | input | 1 | Clear the sticky summary flag |
| quot_o | output | 64 | Quotient of the last completed operation |
| done_o | output | 1 | One-cycle completion strobe |
| cr_o | output | 3 | Condition field {less, greater, equal} |
| cr_valid_o | output | 1 | cr_o updated by this completion |
| ov_o | output | 1 | Overflow flag |
| so_o | output | 1 | Sticky summary overflow flag |

## Verification
A result is due 65 edges after the accepting edge for a nonzero divisor, and at the accepting edge for a zero divisor. All flags appear in the same cycle as `done_o`. The driver computes the exact due cycle for each launched operation and pushes it with the expected quotient and flags. The monitor fails any completion that arrives in another cycle or when no result is pending. The flags that must hold their value are compared at every completion against a running model, and the sticky flag is also checked one cycle after a clear.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  // condition field bit positions
  localparam int unsigned CR_LT = 2;
  localparam int unsigned CR_GT = 1;
  localparam int unsigned CR_EQ = 0;
  localparam int unsigned CR_W  = 3;
endpackage

// File: rtl/udiv_ctrl.sv
module udiv_ctrl #(
  parameter int unsigned W = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic zero_i,
  output logic accept_o,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic zero_fin_o
);
  import udiv_pkg::*;
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;

  div_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    accept_o   = 1'b0;
    load_o     = 1'b0;
    step_o     = 1'b0;
    fin_o      = 1'b0;
    zero_fin_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          if (zero_i) begin
            fin_o      = 1'b1;
            zero_fin_o = 1'b1;
          end else begin
            load_o  = 1'b1;
            cnt_d   = CNT_W'(W - 1);
            state_d = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        step_o = 1'b1;
        if (cnt_q == '0) state_d = ST_FIN;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_FIN: begin
        fin_o   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/udiv_core.sv
module udiv_core #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quot_o
);
  logic [W-1:0] rem_q, qr_q, dvs_q;
  logic [W:0]   trial, diff;
  logic         fits;

  // shift one dividend bit into the partial remainder, try a subtract
  assign trial = {rem_q, qr_q[W-1]};
  assign diff  = trial - {1'b0, dvs_q};
  assign fits  = ~diff[W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      qr_q  <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      qr_q  <= dividend_i;
      dvs_q <= divisor_i;
    end else if (step_i) begin
      rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
      qr_q  <= {qr_q[W-2:0], fits};
    end
  end

  assign quot_o = qr_q;
endmodule

// File: rtl/udiv_flags.sv
module udiv_flags #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fin_i,
  input  logic         zero_i,
  input  logic         ovf_en_i,
  input  logic         rec_i,
  input  logic         so_clr_i,
  input  logic [W-1:0] quot_i,
  output logic [W-1:0] quot_o,
  output logic         done_o,
  output logic [2:0]   cr_o,
  output logic         cr_valid_o,
  output logic         ov_o,
  output logic         so_o
);
  import udiv_pkg::*;

  logic [W-1:0]    res;
  logic [CR_W-1:0] cr_new;
  logic            ov_set;

  assign res = zero_i ? '0 : quot_i;

  always_comb begin
    cr_new = '0;
    if (res == '0)     cr_new[CR_EQ] = 1'b1;
    else if (res[W-1]) cr_new[CR_LT] = 1'b1;
    else               cr_new[CR_GT] = 1'b1;
  end

  assign ov_set = fin_i & ovf_en_i & zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quot_o     <= '0;
      done_o     <= 1'b0;
      cr_o       <= '0;
      cr_valid_o <= 1'b0;
      ov_o       <= 1'b0;
    end else begin
      done_o     <= fin_i;
      cr_valid_o <= fin_i & rec_i;
      if (fin_i) begin
        quot_o <= res;
        if (rec_i)    cr_o <= cr_new;
        if (ovf_en_i) ov_o <= zero_i;
      end
    end
  end

  // sticky summary: set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       so_o <= 1'b0;
    else if (ov_set)   so_o <= 1'b1;
    else if (so_clr_i) so_o <= 1'b0;
  end
endmodule

// File: rtl/udiv_unit.sv
module udiv_unit #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  input  logic         ovf_en_i,
  input  logic         rec_en_i,
  input  logic         so_clr_i,
  output logic [W-1:0] quot_o,
  output logic         done_o,
  output logic [2:0]   cr_o,
  output logic         cr_valid_o,
  output logic         ov_o,
  output logic         so_o
);
  logic accept, load, step, fin, zero_fin, zero_in;
  logic ovf_en_q, rec_q;
  logic fl_ovf_en, fl_rec;
  logic [W-1:0] core_q;

  assign zero_in = (divisor_i == '0);

  udiv_ctrl #(.W(W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .zero_i     (zero_in),
    .accept_o   (accept),
    .load_o     (load),
    .step_o     (step),
    .fin_o      (fin),
    .zero_fin_o (zero_fin)
  );

  udiv_core #(.W(W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .step_i     (step),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .quot_o     (core_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_en_q <= 1'b0;
      rec_q    <= 1'b0;
    end else if (accept) begin
      ovf_en_q <= ovf_en_i;
      rec_q    <= rec_en_i;
    end
  end

  // zero divisor finishes on the accept edge, so it uses live controls
  assign fl_ovf_en = zero_fin ? ovf_en_i : ovf_en_q;
  assign fl_rec    = zero_fin ? rec_en_i : rec_q;

  udiv_flags #(.W(W)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fin_i      (fin),
    .zero_i     (zero_fin),
    .ovf_en_i   (fl_ovf_en),
    .rec_i      (fl_rec),
    .so_clr_i   (so_clr_i),
    .quot_i     (core_q),
    .quot_o     (quot_o),
    .done_o     (done_o),
    .cr_o       (cr_o),
    .cr_valid_o (cr_valid_o),
    .ov_o       (ov_o),
    .so_o       (so_o)
  );
endmodule

// File: rtl/udiv_unit_chk.sv
module udiv_unit_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         so_clr_i,
  input logic [W-1:0] quot_o,
  input logic         done_o,
  input logic [2:0]   cr_o,
  input logic         cr_valid_o,
  input logic         ov_o,
  input logic         so_o
);
  // R1: result only moves on completion
  p_quot_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(quot_o));

  // R4: condition qualifier only with done, exactly one bit set
  p_cr_with_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_valid_o |-> done_o);
  p_cr_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_valid_o |-> ($countones(cr_o) == 1));
  p_cr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cr_valid_o |-> $stable(cr_o));

  // R6: overflow flag moves only on completion
  p_ov_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(ov_o));

  // R7: summary follows overflow, falls only after a clear
  p_so_on_ov_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ov_o) |-> so_o);
  p_so_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(so_o) |-> $past(so_clr_i));
endmodule

bind udiv_unit udiv_unit_chk #(.W(W)) u_chk (.*);

// File: tb/tb_udiv_unit.sv
module tb_udiv_unit;
  localparam int unsigned W = 64;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic         ovf_en_i = 1'b0;
  logic         rec_en_i = 1'b0;
  logic         so_clr_i = 1'b0;
  logic [W-1:0] quot_o;
  logic         done_o;
  logic [2:0]   cr_o;
  logic         cr_valid_o;
  logic         ov_o;
  logic         so_o;

  udiv_unit #(.W(W)) dut (.*);

  always #2 clk_i = ~clk_i;  // 250 MHz

  typedef struct {
    logic [W-1:0] quot;
    logic [2:0]   cr;
    logic         crv;
    logic         ov;
    logic         so;
    int           due;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   finished = 1'b0;

  // running model of held flags
  logic [2:0] cr_m = '0;
  logic       ov_m = 1'b0;
  logic       so_m = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] cr_of(input logic [W-1:0] q);
    if (q == '0)     return 3'b001;
    else if (q[W-1]) return 3'b100;
    else             return 3'b010;
  endfunction

  // driver: launch one op, push expected item
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic oe, input logic rc, input logic clr);
    exp_t e;
    logic zero;
    @(negedge clk_i);
    zero = (b == '0);
    dividend_i = a; divisor_i = b; ovf_en_i = oe; rec_en_i = rc;
    so_clr_i = clr; start_i = 1'b1;
    e.quot = zero ? '0 : a / b;
    if (rc) cr_m = zero ? 3'b001 : cr_of(e.quot);
    if (oe) ov_m = zero;
    if (clr) so_m = 1'b0;
    if (oe && zero) so_m = 1'b1;
    e.cr  = cr_m;
    e.crv = rc;
    e.ov  = ov_m;
    e.so  = so_m;
    e.due = cyc + (zero ? 1 : 66);
    exp_q.push_back(e);
    @(negedge clk_i);
    start_i = 1'b0; so_clr_i = 1'b0;
    // R8: scramble inputs after accept
    dividend_i = {$urandom, $urandom}; divisor_i = {$urandom, $urandom};
    ovf_en_i = ~oe; rec_en_i = ~rc;
    wait (exp_q.size() == 0);
    @(negedge clk_i);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected done", W'(cyc), '0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cyc == e.due, "R1/R3", "done cycle", W'(cyc), W'(e.due));
        chk(quot_o == e.quot, "R2/R3", "quotient", quot_o, e.quot);
        chk(cr_valid_o == e.crv, "R4", "cr_valid", W'(cr_valid_o), W'(e.crv));
        chk(cr_o == e.cr, "R4/R5", "cr", W'(cr_o), W'(e.cr));
        chk(ov_o == e.ov, "R6", "ov", W'(ov_o), W'(e.ov));
        chk(so_o == e.so, "R7", "so", W'(so_o), W'(e.so));
      end
    end
  end

  task automatic clear_so();
    @(negedge clk_i);
    so_clr_i = 1'b1;
    @(negedge clk_i);
    so_clr_i = 1'b0;
    so_m = 1'b0;
    chk(so_o == 1'b0, "R7", "so after clear", W'(so_o), '0);
    chk(ov_o == ov_m, "R7", "ov untouched by clear", W'(ov_o), W'(ov_m));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(quot_o == '0 && done_o == 1'b0 && cr_o == '0 && cr_valid_o == 1'b0
        && ov_o == 1'b0 && so_o == 1'b0, "R9", "reset outputs",
        {quot_o[59:0], done_o, cr_valid_o, ov_o, so_o}, '0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    issue(64'd10, 64'd3, 1'b1, 1'b1, 1'b0);                       // R2 R4 R6
    issue(64'h8000_0000_0000_0005, 64'd1, 1'b0, 1'b1, 1'b0);     // R4 less, divisor 1
    issue(64'd5, 64'd9, 1'b0, 1'b1, 1'b0);                        // R4 equal
    issue('1, 64'd7, 1'b0, 1'b0, 1'b0);                           // R4 no record
    issue('1, '1, 1'b0, 1'b1, 1'b0);                              // R2
    issue(64'h1234_5678_9abc_def0, '0, 1'b1, 1'b1, 1'b0);        // R3 R5 R6 R7
    issue(64'd100, 64'd10, 1'b0, 1'b0, 1'b0);                     // R6 ov held
    clear_so();                                                   // R7
    issue(64'd100, 64'd10, 1'b1, 1'b0, 1'b0);                     // R6 ov cleared
    issue(64'd77, '0, 1'b0, 1'b1, 1'b0);                          // R6 ov untouched on zero
    issue(64'd1, '0, 1'b1, 1'b0, 1'b1);                           // R7 set beats clear

    // R8: start while busy ignored
    fork
      issue(64'hffff_0000_ffff_0000, 64'd3, 1'b0, 1'b1, 1'b0);
      begin
        repeat (12) @(negedge clk_i);
        dividend_i = 64'd9; divisor_i = 64'd0; ovf_en_i = 1'b1; start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
      end
    join
    repeat (80) @(negedge clk_i);
    chk(ov_o == ov_m, "R8", "ov after ignored start", W'(ov_o), W'(ov_m));

    for (int i = 0; i < 10; i++) begin
      logic [W-1:0] a, b;
      a = {$urandom, $urandom};
      b = (i % 3 == 0) ? W'($urandom) : {$urandom, $urandom} >> (i * 5);
      if (b == '0) b = 64'd13;
      issue(a, b, i[0], i[1], 1'b0);
    end

    repeat (5) @(negedge clk_i);
    chk(exp_q.size() == 0, "R1", "pending results", W'(exp_q.size()), '0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule